// File: doc/BRIEF.md
# Three-Channel Residue Multiply-Accumulate Datapath

This block is the arithmetic core of a residue-number FIR filter. It works in three independent channels whose moduli are 2^N, 2^N−1 and 2^(N+1)−1. No carry passes between the channels. On every accepted clock it takes one coefficient residue and one sample residue per channel. It multiplies the pair modulo that channel's modulus and adds the product into the channel's accumulator.

A pass begins with a `start` strobe, which clears all three accumulators. The pass then consumes exactly TAPS valid beats. In the cycle after the last beat, `done` rises for one cycle. From that cycle on, the three outputs hold the FIR result in residue form until the next `start`. The storage of coefficients and samples, and the conversion to and from binary, are handled outside this block.

The two channels whose modulus is one less than a power of two use multipliers without lookup tables. Each partial product is the coefficient gated by one sample bit and rotated left. The partial products are reduced by carry-save adders and a final adder with end-around carry. Every adder in these channels returns zero only as all zeros.

Top module: `rns_fir_mac`

## Requirements
- R1: `acc0` (N bits) equals the sum over the pass of `coef0*samp0`, reduced modulo 2^N.
- R2: `acc1` (N bits) equals the sum over the pass of `coef1*samp1`, reduced modulo 2^N−1, when the inputs lie in 0..2^N−2.
- R3: `acc2` (N+1 bits) equals the sum over the pass of `coef2*samp2`, reduced modulo 2^(N+1)−1, when the inputs lie in 0..2^(N+1)−2.
- R4: `acc1` never shows the all-ones value 2^N−1. `acc2` never shows 2^(N+1)−1. A sum that is a multiple of the modulus reads as 0.
- R5: A cycle with `start` high makes all three accumulators 0 in the following cycle and restarts the tap count. A `valid` beat in that same cycle is ignored.
- R6: Each cycle with `valid` high, `start` low and fewer than TAPS taps taken adds exactly one product per channel. A cycle without `valid` leaves the accumulators unchanged.
- R7: `done` is high for exactly one cycle. That cycle is the one following the clock edge that takes the TAPS-th beat, and in it the accumulators already show the final sums.
- R8: Once TAPS beats have been taken, further `valid` beats are ignored and the accumulators hold until the next `start`.
- R9: After reset all accumulators are 0, `done` is 0, and the block accepts a full pass of TAPS beats without needing a `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the accumulators and tap count |
| valid | input | 1 | Current residues form one tap |
| coef0 | input | N | Coefficient residue, modulus 2^N |
| samp0 | input | N | Sample residue, modulus 2^N |
| coef1 | input | N | Coefficient residue, modulus 2^N−1 |
| samp1 | input | N | Sample residue, modulus 2^N−1 |
| coef2 | input | N+1 | Coefficient residue, modulus 2^(N+1)−1 |
| samp2 | input | N+1 | Sample residue, modulus 2^(N+1)−1 |
| acc0 | output | N | Accumulated residue, modulus 2^N |
| acc1 | output | N | Accumulated residue, modulus 2^N−1 |
| acc2 | output | N+1 | Accumulated residue, modulus 2^(N+1)−1 |
| done | output | 1 | One-cycle pulse after the last tap |

## Verification
The bench builds the block with N = 6 and TAPS = 28, which gives moduli 64, 63 and 127 and a 28-tap pass. With these values, passes in which every residue is the channel maximum drive every end-around carry path and every rotation of the multipliers. A pass built from complementary sample pairs makes each channel's sum an exact multiple of its modulus, so the single-zero rule is exercised. Passes with idle gaps, a `valid` beat alongside `start`, and extra beats after `done` test the tap count at both of its ends.

// File: rtl/rns_mac_pkg.sv
package rns_mac_pkg;

  typedef enum logic [0:0] {
    CH_POW2     = 1'b0,
    CH_MERSENNE = 1'b1
  } ch_kind_e;

endpackage

// File: rtl/rmac_eac_add.sv
// Adder modulo 2^W-1 with end-around carry and a single zero encoding.
module rmac_eac_add #(
  parameter int W = 6
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  logic [W:0]   sum_u;
  logic [W:0]   sum_inc;
  logic [W-1:0] pre;

  always_comb begin
    sum_u   = {1'b0, a} + {1'b0, b};
    sum_inc = sum_u + (W+1)'(1);
    // a carry out of a+b+1 means a+b reached the modulus: keep the wrapped value
    pre     = sum_inc[W] ? sum_inc[W-1:0] : sum_u[W-1:0];
    // all-ones detect folds the redundant zero onto 0
    s       = (&pre) ? '0 : pre;
  end
endmodule

// File: rtl/rmac_m1_mul.sv
// Multiplier modulo 2^W-1 built from rotated, gated partial products.
module rmac_m1_mul #(
  parameter int W = 6
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] p
);
  logic [W-1:0] pp [W];
  logic [W-1:0] sv;
  logic [W-1:0] cv;
  logic [W-1:0] ns;
  logic [W-1:0] mj;

  genvar gs, gi;
  generate
    for (gs = 0; gs < W; gs++) begin : g_row
      for (gi = 0; gi < W; gi++) begin : g_bit
        assign pp[gs][(gi + gs) % W] = y[gs] & x[gi];
      end
    end
  endgenerate

  always_comb begin
    sv = pp[0];
    cv = pp[1];
    ns = '0;
    mj = '0;
    for (int k = 2; k < W; k++) begin
      ns = sv ^ cv ^ pp[k];
      mj = (sv & cv) | (sv & pp[k]) | (cv & pp[k]);
      sv = ns;
      cv = {mj[W-2:0], mj[W-1]};
    end
  end

  rmac_eac_add #(.W(W)) u_final (
    .a (sv),
    .b (cv),
    .s (p)
  );
endmodule

// File: rtl/rmac_p2_mul.sv
// Multiplier modulo 2^W: shifted partial products, carries above W-1 dropped.
module rmac_p2_mul #(
  parameter int W = 6
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] p
);
  always_comb begin
    p = '0;
    for (int s = 0; s < W; s++) begin
      if (y[s]) p = p + (x << s);
    end
  end
endmodule

// File: rtl/rmac_channel.sv
module rmac_channel
  import rns_mac_pkg::*;
#(
  parameter int       W    = 6,
  parameter ch_kind_e KIND = CH_POW2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] coef,
  input  logic [W-1:0] samp,
  output logic [W-1:0] acc
);
  logic [W-1:0] prod;
  logic [W-1:0] sum;
  logic [W-1:0] acc_q;
  logic [W-1:0] acc_d;

  generate
    if (KIND == CH_POW2) begin : g_pow2
      rmac_p2_mul #(.W(W)) u_mul (.x(coef), .y(samp), .p(prod));
      assign sum = acc_q + prod;
    end else begin : g_mers
      rmac_m1_mul  #(.W(W)) u_mul (.x(coef), .y(samp), .p(prod));
      rmac_eac_add #(.W(W)) u_add (.a(acc_q), .b(prod), .s(sum));
    end
  endgenerate

  always_comb begin
    acc_d = acc_q;
    if (clr)     acc_d = '0;
    else if (en) acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/rmac_ctrl.sv
module rmac_ctrl #(
  parameter int TAPS = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic valid,
  output logic clr,
  output logic en,
  output logic done
);
  localparam int CW = $clog2(TAPS + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          done_q;
  logic          done_d;

  always_comb begin
    clr    = start;
    en     = valid && !start && (cnt_q < CW'(TAPS));
    done_d = en && (cnt_q == CW'(TAPS - 1));
    cnt_d  = cnt_q;
    if (start)   cnt_d = '0;
    else if (en) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/rns_fir_mac.sv
module rns_fir_mac
  import rns_mac_pkg::*;
#(
  parameter int N    = 6,
  parameter int TAPS = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         valid,
  input  logic [N-1:0] coef0,
  input  logic [N-1:0] samp0,
  input  logic [N-1:0] coef1,
  input  logic [N-1:0] samp1,
  input  logic [N:0]   coef2,
  input  logic [N:0]   samp2,
  output logic [N-1:0] acc0,
  output logic [N-1:0] acc1,
  output logic [N:0]   acc2,
  output logic         done
);
  localparam int WW = N + 1;

  logic clr;
  logic en;

  rmac_ctrl #(.TAPS(TAPS)) u_ctrl (
    .clk (clk), .rst_n (rst_n), .start (start), .valid (valid),
    .clr (clr), .en (en), .done (done)
  );

  rmac_channel #(.W(N), .KIND(CH_POW2)) u_ch0 (
    .clk (clk), .rst_n (rst_n), .clr (clr), .en (en),
    .coef (coef0), .samp (samp0), .acc (acc0)
  );

  rmac_channel #(.W(N), .KIND(CH_MERSENNE)) u_ch1 (
    .clk (clk), .rst_n (rst_n), .clr (clr), .en (en),
    .coef (coef1), .samp (samp1), .acc (acc1)
  );

  rmac_channel #(.W(WW), .KIND(CH_MERSENNE)) u_ch2 (
    .clk (clk), .rst_n (rst_n), .clr (clr), .en (en),
    .coef (coef2), .samp (samp2), .acc (acc2)
  );
endmodule

// File: rtl/rns_fir_mac_chk.sv
module rns_fir_mac_chk #(
  parameter int N = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         valid,
  input logic [N-1:0] acc0,
  input logic [N-1:0] acc1,
  input logic [N:0]   acc2,
  input logic         done
);
  // R7: done never lasts two cycles
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: start clears every channel and done
  a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc0 == '0) && (acc1 == '0) && (acc2 == '0) && !done);

  // R6: idle cycles leave the accumulators alone
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !start) |=> ($stable(acc0) && $stable(acc1) && $stable(acc2)));

  // R8: after the final tap the results hold unless restarted
  a_r8_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(acc0) && $stable(acc1) && $stable(acc2)));

  // R4: no redundant all-ones zero in the 2^k-1 channels
  a_r4_canonical: assert property (@(posedge clk) disable iff (!rst_n)
    (acc1 != {N{1'b1}}) && (acc2 != {(N+1){1'b1}}));
endmodule

bind rns_fir_mac rns_fir_mac_chk #(.N(N)) u_chk (
  .clk (clk), .rst_n (rst_n), .start (start), .valid (valid),
  .acc0 (acc0), .acc1 (acc1), .acc2 (acc2), .done (done)
);

// File: tb/sim_rns_fir_mac.sv
`timescale 1ns/1ps
module sim_rns_fir_mac;
  localparam int N    = 6;
  localparam int TAPS = 28;
  localparam int M0   = 1 << N;
  localparam int M1   = (1 << N) - 1;
  localparam int M2   = (1 << (N + 1)) - 1;

  typedef struct { int e0; int e1; int e2; } exp_t;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         valid;
  logic [N-1:0] coef0, samp0, coef1, samp1;
  logic [N:0]   coef2, samp2;
  logic [N-1:0] acc0, acc1;
  logic [N:0]   acc2;
  logic         done;

  int   checks;
  int   errors;
  exp_t sb[$];
  logic prev_done;
  int   last_e0, last_e1, last_e2;

  rns_fir_mac #(.N(N), .TAPS(TAPS)) u0 (
    .clk (clk), .rst_n (rst_n), .start (start), .valid (valid),
    .coef0 (coef0), .samp0 (samp0), .coef1 (coef1), .samp1 (samp1),
    .coef2 (coef2), .samp2 (samp2),
    .acc0 (acc0), .acc1 (acc1), .acc2 (acc2), .done (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tapval(int pat, int i, int m, bit is_coef);
    int a;
    case (pat)
      0: tapval = is_coef ? (i + 1) % m : (2 * i + 3) % m;
      1: tapval = m - 1;
      2: tapval = is_coef ? (i * 37 + 11) % m : (i * i * 5 + 7) % m;
      default: begin
        a = m / 2;
        tapval = is_coef ? 1 : ((i % 2 == 0) ? a : m - a);
      end
    endcase
  endfunction

  task automatic set_tap(int pat, int i);
    coef0 = N'(tapval(pat, i, M0, 1'b1));
    samp0 = N'(tapval(pat, i, M0, 1'b0));
    coef1 = N'(tapval(pat, i, M1, 1'b1));
    samp1 = N'(tapval(pat, i, M1, 1'b0));
    coef2 = (N+1)'(tapval(pat, i, M2, 1'b1));
    samp2 = (N+1)'(tapval(pat, i, M2, 1'b0));
  endtask

  // driver: computes the reference, queues it, then plays one pass
  task automatic run_pass(int pat, bit gaps);
    longint s0, s1, s2;
    exp_t   e;
    s0 = 0; s1 = 0; s2 = 0;
    for (int i = 0; i < TAPS; i++) begin
      s0 += longint'(tapval(pat, i, M0, 1'b1)) * tapval(pat, i, M0, 1'b0);
      s1 += longint'(tapval(pat, i, M1, 1'b1)) * tapval(pat, i, M1, 1'b0);
      s2 += longint'(tapval(pat, i, M2, 1'b1)) * tapval(pat, i, M2, 1'b0);
    end
    e.e0 = int'(s0 % M0); e.e1 = int'(s1 % M1); e.e2 = int'(s2 % M2);
    last_e0 = e.e0; last_e1 = e.e1; last_e2 = e.e2;
    sb.push_back(e);

    // start together with a valid beat: the beat must be dropped (R5)
    @(posedge clk); #1;
    start = 1'b1; valid = 1'b1; set_tap(1, 0);
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < TAPS; i++) begin
      if (gaps && (i % 5 == 2)) begin
        valid = 1'b0; set_tap(1, i);
        @(posedge clk); #1;
      end
      valid = 1'b1; set_tap(pat, i);
      if (i == 0) begin
        @(negedge clk);
        check("R5 acc0 cleared", int'(acc0), 0);
        check("R5 acc1 cleared", int'(acc1), 0);
        check("R5 acc2 cleared", int'(acc2), 0);
      end
      @(posedge clk); #1;
    end
    valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    // extra beats after the pass must not change anything (R8)
    valid = 1'b1; set_tap(1, 0);
    repeat (3) @(posedge clk);
    #1;
    valid = 1'b0;
    @(negedge clk);
    check("R8 acc0 held", int'(acc0), last_e0);
    check("R8 acc1 held", int'(acc1), last_e1);
    check("R8 acc2 held", int'(acc2), last_e2);
    check("R8 no second done", int'(done), 0);
  endtask

  // monitor: pops the scoreboard whenever done is seen
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) begin
        checks++; errors++;
        $display("FAIL R7: done high two cycles, actual 1 expected 0");
      end
      if (done && !prev_done) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7: unexpected done, actual 1 expected 0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check("R1 acc0", int'(acc0), e.e0);
          check("R2 acc1", int'(acc1), e.e1);
          check("R3 acc2", int'(acc2), e.e2);
          checks++;
          if (acc1 == {N{1'b1}} || acc2 == {(N+1){1'b1}}) begin
            errors++;
            $display("FAIL R4: all-ones residue, actual %0d/%0d expected canonical",
                     acc1, acc2);
          end
        end
      end
      prev_done <= done;
    end else begin
      prev_done <= 1'b0;
    end
  end

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; start = 1'b0; valid = 1'b0;
    set_tap(0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R9 acc0 reset", int'(acc0), 0);
    check("R9 acc1 reset", int'(acc1), 0);
    check("R9 acc2 reset", int'(acc2), 0);
    check("R9 done reset", int'(done), 0);

    // R9: a full pass straight out of reset, no start
    begin
      longint s0, s1, s2;
      exp_t e;
      s0 = 0; s1 = 0; s2 = 0;
      for (int i = 0; i < TAPS; i++) begin
        s0 += longint'(tapval(0, i, M0, 1'b1)) * tapval(0, i, M0, 1'b0);
        s1 += longint'(tapval(0, i, M1, 1'b1)) * tapval(0, i, M1, 1'b0);
        s2 += longint'(tapval(0, i, M2, 1'b1)) * tapval(0, i, M2, 1'b0);
      end
      e.e0 = int'(s0 % M0); e.e1 = int'(s1 % M1); e.e2 = int'(s2 % M2);
      sb.push_back(e);
      @(posedge clk); #1;
      for (int i = 0; i < TAPS; i++) begin
        valid = 1'b1; set_tap(0, i);
        @(posedge clk); #1;
      end
      valid = 1'b0;
      repeat (3) @(posedge clk);
    end

    run_pass(0, 1'b0);   // ramp values
    run_pass(1, 1'b0);   // every residue at its maximum
    run_pass(2, 1'b1);   // scattered values with idle gaps (R6)
    run_pass(3, 1'b0);   // sums that are exact multiples (R4)
    check("R4 acc1 zero-sum", int'(acc1), 0);
    check("R4 acc2 zero-sum", int'(acc2), 0);
    check("R7 all passes reported", sb.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule